// File: doc/BRIEF.md
# Interrupt Event Router

This block collects a wide vector of system event inputs and steers each one to one of a smaller set of host interrupt lines. Two programmable lookups sit between them. Each event has a 4-bit channel number, and each channel has a 4-bit host number. Software works the block through a simple synchronous register port. Single-index command registers set or clear one status bit, one enable bit or one host enable with a single write, so software never has to read, modify and write a shared word.

Every event input first passes through conditioning, which applies a polarity and picks level or edge sensitivity. The conditioned input then latches into a raw status bit. A raw bit that is also enabled is pending. For each host, the block picks the pending event on the lowest-numbered channel routed to that host, and the lowest event number within that channel. The result can be read as a pending index. A host line is asserted while the global enable is on, that host is enabled, and something is pending for it.

Top module: `evr_router`

## Requirements
- R1: After reset the global enable, every event enable, every host enable, every raw status bit and every map lane read 0. Every polarity bit reads 1 and every type bit reads 0. Every host output is low, and every pending-index word reads 0x8000_0000.
- R2: Writing an event number to 0x20 sets that event's raw status, and writing it to 0x24 clears it. Raw status reads back at 0x200 + 4·n, with bit i of word n standing for event 32·n + i. A number of N_EVT or more is ignored.
- R3: Writing an event number to 0x28 enables that event, and writing it to 0x2C disables it. A write to 0x300 + 4·n sets the enables for every 1 bit in the data, and a write to 0x380 + 4·n clears them. Both addresses read back the enable bits.
- R4: Writing a host number to 0x34 enables that host output, and writing it to 0x38 disables it.
- R5: Bit 0 of the register at 0x10 is the global enable. While it is 0, every host output is low, but pending-index reads are unaffected.
- R6: A read of 0x280 + 4·n returns raw status AND enable. A write there clears the raw status bit of each 1 in the data, whether or not that event is enabled.
- R7: Event map words start at 0x400, and channel map words start at 0x800. Each word holds four entries in 8-bit lanes, with lane k at bits 8k+3:8k for entry 4·word + k. Only the low 4 bits of a lane are stored. The other lane bits, and lanes for channels that do not exist, read 0.
- R8: A read of 0x900 + 4·h returns the chosen event number in bits 9:0 and 0 elsewhere. It reads 0x8000_0000 when nothing is pending for host h.
- R9: Among the pending events routed to a host, the one on the lowest channel number wins. Within that channel, the lowest event number wins.
- R10: host_irq[h] is high exactly when the global enable is on, host h is enabled, and at least one pending event maps through its channel to h. An event mapped to a channel number of N_CH or more reaches no host.
- R11: Polarity bit 1 at 0xD00 + 4·n makes an input active high, and 0 makes it active low. A level event whose input is at its active value sets its raw status.
- R12: Type bit 1 at 0xD80 + 4·n selects edge sensitivity. The raw bit then sets only on an inactive-to-active change and stays clear after a clear while the input is held. A level-type event sets again while its input stays active, so a set in the same cycle as a clear wins.
- R13: rdata is registered. It takes the addressed value one cycle after a cycle with rd_en high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| evt_in | input | N_EVT | System event inputs |
| host_irq | output | N_HOST | Host interrupt lines |

## Verification
The assertions assume that the register port never raises rd_en and wr_en in the same cycle. They also assume that any single write names one register. The stimulus always drives one access per task, with strobes changed on the falling edge and dropped again one cycle later. The route assertion also relies on the maps being stable whenever a pending index is chosen. The stimulus reprograms maps only as whole-word writes, and no event input moves at the same time. Event inputs change only on falling edges, and the bench waits a full cycle before any read that depends on them.

// File: rtl/evr_pkg.sv
`timescale 1ns/1ps
package evr_pkg;
    localparam int ADDR_W = 12;
    localparam int IDX_W  = 10;
    localparam int MAP_W  = 4;

    typedef enum logic [4:0] {
        RG_NONE, RG_GLB, RG_SSET, RG_SCLR, RG_ESET, RG_ECLR, RG_HSET, RG_HCLR,
        RG_RAW, RG_STAT, RG_ENS, RG_ENC, RG_EMAP, RG_CMAP, RG_PIDX, RG_POL, RG_TYP
    } region_e;

    typedef struct packed {
        logic             found;
        logic [IDX_W-1:0] idx;
    } pick_t;

    function automatic region_e decode_region(input logic [ADDR_W-1:0] a);
        region_e r;
        r = RG_NONE;
        if (a[11:10] == 2'b01)      r = RG_EMAP;
        else if (a[11:8] == 4'h8)   r = RG_CMAP;
        else if (a[11:8] == 4'h9)   r = RG_PIDX;
        else begin
            case (a[11:7])
                5'd0: begin
                    case (a[6:0])
                        7'h10: r = RG_GLB;
                        7'h20: r = RG_SSET;
                        7'h24: r = RG_SCLR;
                        7'h28: r = RG_ESET;
                        7'h2C: r = RG_ECLR;
                        7'h34: r = RG_HSET;
                        7'h38: r = RG_HCLR;
                        default: r = RG_NONE;
                    endcase
                end
                5'd4:  r = RG_RAW;
                5'd5:  r = RG_STAT;
                5'd6:  r = RG_ENS;
                5'd7:  r = RG_ENC;
                5'd26: r = RG_POL;
                5'd27: r = RG_TYP;
                default: r = RG_NONE;
            endcase
        end
        return r;
    endfunction

    function automatic logic [31:0] pidx_word(input pick_t p);
        return p.found ? {{(32-IDX_W){1'b0}}, p.idx} : 32'h8000_0000;
    endfunction
endpackage

// File: rtl/evr_latch.sv
`timescale 1ns/1ps
module evr_latch #(
    parameter int N_EVT = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_EVT-1:0] evt_in,
    input  logic [N_EVT-1:0] pol,
    input  logic [N_EVT-1:0] edge_mode,
    input  logic [N_EVT-1:0] set_sw,
    input  logic [N_EVT-1:0] clr_sw,
    output logic [N_EVT-1:0] raw
);
    logic [N_EVT-1:0] act, prev_q, hw_set;

    // active when input equals polarity bit
    assign act    = ~(evt_in ^ pol);
    assign hw_set = (edge_mode & act & ~prev_q) | (~edge_mode & act);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            raw    <= '0;
        end else begin
            prev_q <= act;
            raw    <= (raw & ~clr_sw) | hw_set | set_sw;
        end
    end

    assert_raw_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (|clr_sw) |=> ((raw & $past(clr_sw & ~(set_sw | hw_set))) == '0));

    assert_raw_set_R2: assert property (@(posedge clk) disable iff (rst)
        (|set_sw) |=> ((raw & $past(set_sw)) == $past(set_sw)));
endmodule

// File: rtl/evr_route.sv
`timescale 1ns/1ps
module evr_route import evr_pkg::*; #(
    parameter int N_EVT  = 64,
    parameter int N_CH   = 10,
    parameter int N_HOST = 10
) (
    input  logic [N_EVT-1:0]             pend,
    input  logic [N_EVT-1:0][MAP_W-1:0]  emap,
    input  logic [N_CH-1:0][MAP_W-1:0]   cmap,
    output pick_t [N_HOST-1:0]           pick
);
    pick_t [N_CH-1:0] ch_pick;

    // stage 1: lowest pending event per channel
    always_comb begin
        for (int c = 0; c < N_CH; c++) begin
            ch_pick[c] = '0;
            for (int e = N_EVT - 1; e >= 0; e--) begin
                if (pend[e] && emap[e] == MAP_W'(c)) begin
                    ch_pick[c].found = 1'b1;
                    ch_pick[c].idx   = IDX_W'(e);
                end
            end
        end
    end

    // stage 2: lowest active channel per host
    always_comb begin
        for (int h = 0; h < N_HOST; h++) begin
            pick[h] = '0;
            for (int c = N_CH - 1; c >= 0; c--) begin
                if (ch_pick[c].found && cmap[c] == MAP_W'(h)) begin
                    pick[h] = ch_pick[c];
                end
            end
        end
    end
endmodule

// File: rtl/evr_router.sv
`timescale 1ns/1ps
module evr_router import evr_pkg::*; #(
    parameter int N_EVT  = 64,
    parameter int N_CH   = 10,
    parameter int N_HOST = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [N_EVT-1:0]  evt_in,
    output logic [N_HOST-1:0] host_irq
);
    localparam int NB  = (N_EVT + 31) / 32;
    localparam int EVP = NB * 32;
    localparam int EMW = (N_EVT + 3) / 4;
    localparam int CMW = (N_CH + 3) / 4;
    localparam int EW  = $clog2(N_EVT);
    localparam int HW  = $clog2(N_HOST);

    region_e rg;
    assign rg = decode_region(addr);

    logic                         glb_q;
    logic [N_HOST-1:0]            hen_q;
    logic [N_EVT-1:0]             en_q, pol_q, typ_q, raw, pend;
    logic [EVP-1:0]               en_p, pol_p, typ_p, raw_p, bmask, bank_src;
    logic [EVP-1:0]               en_nx, pol_nx, typ_nx;
    logic [N_EVT-1:0]             evt_hot, set_sw, clr_sw;
    logic [N_HOST-1:0]            host_hot, found;
    logic [N_EVT-1:0][MAP_W-1:0]  emap_q;
    logic [N_CH-1:0][MAP_W-1:0]   cmap_q;
    logic [EMW*4-1:0][MAP_W-1:0]  emap_p;
    logic [CMW*4-1:0][MAP_W-1:0]  cmap_p;
    pick_t [N_HOST-1:0]           pick;
    logic [31:0]                  rd_word;

    assign en_p  = EVP'(en_q);
    assign pol_p = EVP'(pol_q);
    assign typ_p = EVP'(typ_q);
    assign raw_p = EVP'(raw);
    assign pend  = raw & en_q;

    // index decode for single-bit command registers
    always_comb begin
        evt_hot  = '0;
        host_hot = '0;
        for (int e = 0; e < N_EVT; e++)
            if (wdata == 32'(e)) evt_hot[e] = 1'b1;
        for (int h = 0; h < N_HOST; h++)
            if (wdata == 32'(h)) host_hot[h] = 1'b1;
    end

    // banked write data placed at its event positions
    always_comb begin
        bmask = '0;
        for (int b = 0; b < NB; b++)
            if (int'(addr[6:2]) == b) bmask[b*32 +: 32] = wdata;
    end

    assign set_sw = (wr_en && rg == RG_SSET) ? evt_hot : '0;
    assign clr_sw = ((wr_en && rg == RG_SCLR) ? evt_hot : '0)
                  | ((wr_en && rg == RG_STAT) ? bmask[N_EVT-1:0] : '0);

    always_comb begin
        en_nx  = en_p;
        pol_nx = pol_p;
        typ_nx = typ_p;
        if (wr_en) begin
            case (rg)
                RG_ESET: en_nx = en_p | EVP'(evt_hot);
                RG_ECLR: en_nx = en_p & ~EVP'(evt_hot);
                RG_ENS:  en_nx = en_p | bmask;
                RG_ENC:  en_nx = en_p & ~bmask;
                default: ;
            endcase
            for (int b = 0; b < NB; b++) begin
                if (int'(addr[6:2]) == b && rg == RG_POL) pol_nx[b*32 +: 32] = wdata;
                if (int'(addr[6:2]) == b && rg == RG_TYP) typ_nx[b*32 +: 32] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            glb_q <= 1'b0;
            hen_q <= '0;
            en_q  <= '0;
            pol_q <= '1;
            typ_q <= '0;
        end else begin
            if (wr_en && rg == RG_GLB)  glb_q <= wdata[0];
            if (wr_en && rg == RG_HSET) hen_q <= hen_q | host_hot;
            if (wr_en && rg == RG_HCLR) hen_q <= hen_q & ~host_hot;
            en_q  <= en_nx[N_EVT-1:0];
            pol_q <= pol_nx[N_EVT-1:0];
            typ_q <= typ_nx[N_EVT-1:0];
        end
    end

    // map registers, one 4-bit lane per entry
    for (genvar e = 0; e < EMW * 4; e++) begin : g_emap
        if (e < N_EVT) begin : g_real
            always_ff @(posedge clk) begin
                if (rst) emap_q[e] <= '0;
                else if (wr_en && rg == RG_EMAP && int'(addr[9:2]) == e / 4)
                    emap_q[e] <= wdata[(e % 4) * 8 +: MAP_W];
            end
            assign emap_p[e] = emap_q[e];
        end else begin : g_pad
            assign emap_p[e] = '0;
        end
    end

    for (genvar c = 0; c < CMW * 4; c++) begin : g_cmap
        if (c < N_CH) begin : g_real
            always_ff @(posedge clk) begin
                if (rst) cmap_q[c] <= '0;
                else if (wr_en && rg == RG_CMAP && int'(addr[7:2]) == c / 4)
                    cmap_q[c] <= wdata[(c % 4) * 8 +: MAP_W];
            end
            assign cmap_p[c] = cmap_q[c];
        end else begin : g_pad
            assign cmap_p[c] = '0;
        end
    end

    evr_latch #(.N_EVT(N_EVT)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .evt_in   (evt_in),
        .pol      (pol_q),
        .edge_mode(typ_q),
        .set_sw   (set_sw),
        .clr_sw   (clr_sw),
        .raw      (raw)
    );

    evr_route #(.N_EVT(N_EVT), .N_CH(N_CH), .N_HOST(N_HOST)) u_route (
        .pend(pend),
        .emap(emap_q),
        .cmap(cmap_q),
        .pick(pick)
    );

    for (genvar h = 0; h < N_HOST; h++) begin : g_host
        assign found[h] = pick[h].found;
    end
    assign host_irq = {N_HOST{glb_q}} & hen_q & found;

    // read path
    always_comb begin
        case (rg)
            RG_RAW:         bank_src = raw_p;
            RG_STAT:        bank_src = raw_p & en_p;
            RG_ENS, RG_ENC: bank_src = en_p;
            RG_POL:         bank_src = pol_p;
            RG_TYP:         bank_src = typ_p;
            default:        bank_src = '0;
        endcase
    end

    always_comb begin
        rd_word = '0;
        case (rg)
            RG_GLB: rd_word = {31'b0, glb_q};
            RG_RAW, RG_STAT, RG_ENS, RG_ENC, RG_POL, RG_TYP:
                for (int b = 0; b < NB; b++)
                    if (int'(addr[6:2]) == b) rd_word = bank_src[b*32 +: 32];
            RG_EMAP:
                for (int k = 0; k < EMW; k++)
                    if (int'(addr[9:2]) == k)
                        for (int l = 0; l < 4; l++)
                            rd_word[l*8 +: MAP_W] = emap_p[k*4 + l];
            RG_CMAP:
                for (int k = 0; k < CMW; k++)
                    if (int'(addr[7:2]) == k)
                        for (int l = 0; l < 4; l++)
                            rd_word[l*8 +: MAP_W] = cmap_p[k*4 + l];
            RG_PIDX:
                for (int h = 0; h < N_HOST; h++)
                    if (int'(addr[7:2]) == h) rd_word = pidx_word(pick[h]);
            default: rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_word;
    end

    assert_glb_off_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rg == RG_GLB && !wdata[0]) |=> (host_irq == '0));

    assert_host_off_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rg == RG_HCLR && wdata < 32'(N_HOST)) |=> !host_irq[$past(wdata[HW-1:0])]);

    assert_en_set_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rg == RG_ESET && wdata < 32'(N_EVT)) |=> en_q[$past(wdata[EW-1:0])]);

    for (genvar h = 0; h < N_HOST; h++) begin : g_chk
        assert_pick_route_R10: assert property (@(posedge clk) disable iff (rst)
            pick[h].found |-> (pend[pick[h].idx[EW-1:0]]
                && int'(cmap_p[emap_p[pick[h].idx[EW-1:0]]]) == h));
    end
endmodule

// File: tb/sim_evr_router.sv
`timescale 1ns/1ps
module sim_evr_router;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] evt_in = '0;
    logic [9:0]  host_irq;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    evr_router u0 (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .evt_in(evt_in), .host_irq(host_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic t_reset;
        rdchk("R1 glb", 12'h010, 32'h0);
        rdchk("R1 emap", 12'h400, 32'h0);
        rdchk("R1 cmap", 12'h800, 32'h0);
        rdchk("R1 pol0", 12'hD00, 32'hFFFF_FFFF);
        rdchk("R1 pol1", 12'hD04, 32'hFFFF_FFFF);
        rdchk("R1 typ", 12'hD80, 32'h0);
        rdchk("R1 en", 12'h300, 32'h0);
        rdchk("R1 pidx", 12'h900, 32'h8000_0000);
        chk("R1 irq", 32'(host_irq), 32'h0);
    endtask

    task automatic t_readhold;
        rdchk("R13 first", 12'hD00, 32'hFFFF_FFFF);
        wr(12'h010, 32'h1);
        @(negedge clk);
        chk("R13 hold", rdata, 32'hFFFF_FFFF);
        rdchk("R13 new", 12'h010, 32'h1);
    endtask

    task automatic t_raw;
        wr(12'h020, 5);
        rdchk("R2 set5", 12'h200, 32'h20);
        wr(12'h020, 40);
        rdchk("R2 set40", 12'h204, 32'h100);
        wr(12'h024, 5);
        rdchk("R2 clr5", 12'h200, 32'h0);
        wr(12'h020, 64);
        rdchk("R2 oor lo", 12'h200, 32'h0);
        rdchk("R2 oor hi", 12'h204, 32'h100);
        wr(12'h024, 40);
        rdchk("R2 clr40", 12'h204, 32'h0);
    endtask

    task automatic t_enable;
        wr(12'h028, 3);
        rdchk("R3 eset", 12'h300, 32'h8);
        rdchk("R3 eclr view", 12'h380, 32'h8);
        wr(12'h304, 32'h1);
        rdchk("R3 bank set", 12'h304, 32'h1);
        wr(12'h384, 32'h1);
        rdchk("R3 bank clr", 12'h304, 32'h0);
        wr(12'h02C, 3);
        rdchk("R3 disable", 12'h300, 32'h0);
    endtask

    task automatic t_status;
        wr(12'h020, 7);
        wr(12'h020, 9);
        wr(12'h028, 7);
        rdchk("R6 stat", 12'h280, 32'h80);
        wr(12'h280, 32'h280);
        rdchk("R6 w1c raw", 12'h200, 32'h0);
        wr(12'h02C, 7);
    endtask

    task automatic t_maps;
        wr(12'h404, 32'hFFFF_FF03);
        rdchk("R7 emap", 12'h404, 32'h0F0F_0F03);
        wr(12'h808, 32'hFFFF_FFFF);
        rdchk("R7 cmap edge", 12'h808, 32'h0000_0F0F);
        wr(12'h404, 0);
        wr(12'h808, 0);
        rdchk("R7 cleared", 12'h404, 32'h0);
    endtask

    task automatic t_route;
        wr(12'h010, 1);
        wr(12'h40C, 32'h02);
        wr(12'h414, 32'h0101);
        wr(12'h800, 32'h0003_0300);
        wr(12'h034, 3);
        wr(12'h028, 12);
        wr(12'h028, 20);
        wr(12'h028, 21);
        wr(12'h020, 12);
        chk("R10 irq", 32'(host_irq), 32'h8);
        rdchk("R8 pidx12", 12'h90C, 32'd12);
        rdchk("R8 none h0", 12'h900, 32'h8000_0000);
        wr(12'h020, 21);
        rdchk("R9 chan", 12'h90C, 32'd21);
        wr(12'h020, 20);
        rdchk("R9 event", 12'h90C, 32'd20);
        wr(12'h024, 20);
        rdchk("R9 next", 12'h90C, 32'd21);
        wr(12'h024, 21);
        rdchk("R9 last", 12'h90C, 32'd12);
        wr(12'h010, 0);
        chk("R5 gated", 32'(host_irq), 32'h0);
        rdchk("R5 pidx kept", 12'h90C, 32'd12);
        wr(12'h010, 1);
        chk("R5 back", 32'(host_irq), 32'h8);
        wr(12'h038, 3);
        chk("R4 off", 32'(host_irq), 32'h0);
        wr(12'h034, 3);
        chk("R4 on", 32'(host_irq), 32'h8);
        wr(12'h40C, 32'h0C);
        chk("R10 bad chan", 32'(host_irq), 32'h0);
        rdchk("R10 bad pidx", 12'h90C, 32'h8000_0000);
        wr(12'h40C, 32'h02);
        wr(12'h02C, 12);
        chk("R10 disabled", 32'(host_irq), 32'h0);
        wr(12'h024, 12);
        wr(12'h02C, 20);
        wr(12'h02C, 21);
    endtask

    task automatic t_polarity;
        wr(12'hD00, 32'hFFFF_FFFB);
        rdchk("R11 low active", 12'h200, 32'h4);
        wr(12'hD00, 32'hFFFF_FFFF);
        wr(12'h024, 2);
        rdchk("R11 restored", 12'h200, 32'h0);
    endtask

    task automatic t_edge;
        wr(12'hD84, 32'h2);
        @(negedge clk);
        evt_in[33] = 1'b1;
        evt_in[34] = 1'b1;
        @(negedge clk);
        rdchk("R12 both", 12'h204, 32'h6);
        wr(12'h024, 33);
        wr(12'h024, 34);
        rdchk("R12 edge stays, level relatch", 12'h204, 32'h4);
        evt_in[33] = 1'b0;
        @(negedge clk);
        evt_in[33] = 1'b1;
        @(negedge clk);
        rdchk("R12 new edge", 12'h204, 32'h6);
        evt_in[33] = 1'b0;
        evt_in[34] = 1'b0;
        @(negedge clk);
        wr(12'h024, 33);
        wr(12'h024, 34);
        wr(12'hD84, 0);
        rdchk("R12 clean", 12'h204, 32'h0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_readhold();
        t_raw();
        t_enable();
        t_status();
        t_maps();
        t_route();
        t_polarity();
        t_edge();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule